// File: doc/BRIEF.md
# Three-Wire Serial Divider Configuration Loader

This block receives divider settings for a frequency synthesizer over a three-line serial port made of a data line, a shift clock and a load-enable line. All three lines are brought into the system clock domain through synchronizer chains, and their edges are found there. Each rising edge of the shift clock moves one data bit into a shift register, most significant bit first.

The bit shifted in last is a selector. When the load-enable line rises, the selector picks one of two output latch sets. One set holds the reference divide ratio and the prescaler modulus select. The other holds the swallow count and the main count. The latch set that was written gives a single-cycle strobe. If the load-enable line changes level while the shift clock is high, the transfer is refused and a one-cycle error pulse is raised.

Top module: `serial_cfg_loader`

## Requirements
- R1: Each rising edge of `sclk_i` shifts `sdata_i` into bit 0 of the 19-bit shift register, and the older bits move one place up, so the first bit sent ends at bit 18 and the last bit sent is bit 0.
- R2: When bit 0 is 1, a commit loads `ref_ratio_o` from bits 14..1 and `presc_sel_o` from bit 15. Bits 16..18 have no effect.
- R3: When bit 0 is 0, a commit loads `swallow_o` from bits 7..1 and `main_cnt_o` from bits 18..8.
- R4: A commit happens only on a low-to-high transition of `sle_i` while `sclk_i` is low. Shifting without such a transition changes no output. A falling `sle_i` also changes no output.
- R5: A commit raises exactly one one-cycle strobe: `ref_load_o` for the reference set or `div_load_o` for the divider set. The latch set that was not selected keeps its values.
- R6: A level change on `sle_i` while `sclk_i` is high raises `timing_err_o` for one cycle. No latch is updated and no strobe is raised for that change.
- R7: After reset, every latched field and every strobe is 0.
- R8: When more than 19 bits are shifted before a commit, only the last 19 bits take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial shift clock (asynchronous) |
| sdata_i | input | 1 | Serial data, MSB first (asynchronous) |
| sle_i | input | 1 | Load enable; a rising edge commits the word (asynchronous) |
| ref_ratio_o | output | 14 | Reference divide ratio |
| presc_sel_o | output | 1 | Prescaler modulus select |
| swallow_o | output | 7 | Swallow count |
| main_cnt_o | output | 11 | Main count |
| ref_load_o | output | 1 | One-cycle strobe when the reference set is written |
| div_load_o | output | 1 | One-cycle strobe when the divider set is written |
| timing_err_o | output | 1 | One-cycle pulse when load enable changes while the shift clock is high |

## Verification
The assertions assume that each level of `sclk_i` and `sle_i` lasts longer than the synchronizer depth plus one system cycle, so that no edge is lost. They also assume that `sdata_i` settles before `sclk_i` rises, so that the data and clock samples taken in one system cycle agree. The stimulus respects this: it holds every serial level for four system cycles and changes data only while the shift clock is low. The error cases are produced on purpose by moving `sle_i` while `sclk_i` is held high.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  typedef enum logic {
    DEST_DIV = 1'b0,
    DEST_REF = 1'b1
  } dest_e;

  typedef struct packed {
    logic sclk_lvl;
    logic sdata;
    logic sclk_rise;
    logic le_rise;
    logic le_chg;
  } line_evt_t;

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W      = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign sync_o = stg[STAGES-1];

endmodule

// File: rtl/cfg_edge.sv
module cfg_edge
  import cfg_loader_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sclk_s_i,
  input  logic      sdata_s_i,
  input  logic      le_s_i,
  output line_evt_t evt_o
);

  logic sclk_q, le_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      le_q   <= 1'b0;
    end else begin
      sclk_q <= sclk_s_i;
      le_q   <= le_s_i;
    end
  end

  always_comb begin
    evt_o.sclk_lvl  = sclk_s_i;
    evt_o.sdata     = sdata_s_i;
    evt_o.sclk_rise = sclk_s_i & ~sclk_q;
    evt_o.le_rise   = le_s_i & ~le_q;
    evt_o.le_chg    = le_s_i ^ le_q;
  end

  // an edge of one kind cannot repeat on the next cycle
  p_le_rise_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o.le_rise |=> !evt_o.le_rise);

endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
  parameter int unsigned W = 19
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_en_i,
  input  logic         bit_i,
  output logic [W-1:0] word_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         word_o <= '0;
    else if (shift_en_i) word_o <= {word_o[W-2:0], bit_i};
  end

  p_shift_in_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en_i |=> (word_o[0] == $past(bit_i)) && (word_o[W-1:1] == $past(word_o[W-2:0])));

  p_shift_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_en_i |=> $stable(word_o));

endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned REF_W       = 14,
  parameter int unsigned SWAL_W      = 7,
  parameter int unsigned MAIN_W      = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              sle_i,
  output logic [REF_W-1:0]  ref_ratio_o,
  output logic              presc_sel_o,
  output logic [SWAL_W-1:0] swallow_o,
  output logic [MAIN_W-1:0] main_cnt_o,
  output logic              ref_load_o,
  output logic              div_load_o,
  output logic              timing_err_o
);

  localparam int unsigned REF_SPAN = REF_W + 1;
  localparam int unsigned DIV_SPAN = SWAL_W + MAIN_W;
  localparam int unsigned WORD_W   = 1 + ((REF_SPAN > DIV_SPAN) ? REF_SPAN : DIV_SPAN);

  logic [2:0]        line_s;
  line_evt_t         evt;
  logic [WORD_W-1:0] word;
  logic              commit_ok;
  dest_e             dest;

  cfg_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({sle_i, sdata_i, sclk_i}),
    .sync_o (line_s)
  );

  cfg_edge u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sclk_s_i (line_s[0]),
    .sdata_s_i(line_s[1]),
    .le_s_i   (line_s[2]),
    .evt_o    (evt)
  );

  cfg_shift #(.W(WORD_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .shift_en_i(evt.sclk_rise),
    .bit_i     (evt.sdata),
    .word_o    (word)
  );

  assign commit_ok = evt.le_rise & ~evt.sclk_lvl;
  assign dest      = dest_e'(word[0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_ratio_o  <= '0;
      presc_sel_o  <= 1'b0;
      swallow_o    <= '0;
      main_cnt_o   <= '0;
      ref_load_o   <= 1'b0;
      div_load_o   <= 1'b0;
      timing_err_o <= 1'b0;
    end else begin
      ref_load_o   <= 1'b0;
      div_load_o   <= 1'b0;
      timing_err_o <= evt.le_chg & evt.sclk_lvl;
      if (commit_ok) begin
        if (dest == DEST_REF) begin
          ref_ratio_o <= word[REF_W:1];
          presc_sel_o <= word[REF_W+1];
          ref_load_o  <= 1'b1;
        end else begin
          swallow_o   <= word[SWAL_W:1];
          main_cnt_o  <= word[SWAL_W+MAIN_W:SWAL_W+1];
          div_load_o  <= 1'b1;
        end
      end
    end
  end

  p_load_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ref_load_o, div_load_o}));

  p_ref_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_load_o |=> !ref_load_o);

  p_div_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_load_o |=> !div_load_o);

  p_ref_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_load_o |-> ($stable(ref_ratio_o) && $stable(presc_sel_o)));

  p_div_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !div_load_o |-> ($stable(swallow_o) && $stable(main_cnt_o)));

  p_err_no_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timing_err_o |-> !(ref_load_o || div_load_o));

  p_err_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timing_err_o |=> !timing_err_o);

endmodule

// File: tb/sim_serial_cfg_loader.sv
`timescale 1ns/1ps
module sim_serial_cfg_loader;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0, sdata = 1'b0, sle = 1'b0;
  logic [13:0] ref_ratio;
  logic        presc;
  logic [6:0]  swallow;
  logic [10:0] main_cnt;
  logic        ref_load, div_load, terr;

  int checks = 0, errors = 0;
  int ref_cnt = 0, div_cnt = 0, err_cnt = 0;
  bit done = 1'b0;

  logic [13:0] e_ref;
  logic        e_presc;
  logic [6:0]  e_sw;
  logic [10:0] e_main;

  localparam int NV = 7;
  localparam logic [18:0] VEC [NV] = '{
    19'h50007, 19'h00600, 19'h7FFFE, 19'h7FFFF,
    19'h2AAAA, 19'h55555, 19'h00001
  };

  always #2 clk = ~clk;

  serial_cfg_loader u0 (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdata_i(sdata), .sle_i(sle),
    .ref_ratio_o(ref_ratio), .presc_sel_o(presc), .swallow_o(swallow),
    .main_cnt_o(main_cnt), .ref_load_o(ref_load), .div_load_o(div_load),
    .timing_err_o(terr)
  );

  always @(negedge clk) begin
    if (ref_load) ref_cnt++;
    if (div_load) div_cnt++;
    if (terr)     err_cnt++;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(logic [31:0] w, int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdata = w[i];
      idle(4);
      sclk = 1'b1;
      idle(4);
      sclk = 1'b0;
      idle(4);
    end
  endtask

  task automatic pulse_le();
    sle = 1'b1;
    idle(8);
    sle = 1'b0;
    idle(8);
  endtask

  // expected latch update from the requirement field map
  task automatic model_commit(logic [18:0] w);
    if (w[0]) begin
      e_ref   = w[14:1];
      e_presc = w[15];
    end else begin
      e_sw   = w[7:1];
      e_main = w[18:8];
    end
  endtask

  task automatic check_fields(string req);
    check(req, 32'(ref_ratio), 32'(e_ref));
    check(req, 32'(presc),     32'(e_presc));
    check(req, 32'(swallow),   32'(e_sw));
    check(req, 32'(main_cnt),  32'(e_main));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int r0, d0, x0;
    e_ref = '0; e_presc = 1'b0; e_sw = '0; e_main = '0;
    idle(5);
    // R7: reset state
    check("R7 ref_load", 32'(ref_load), 0);
    check("R7 div_load", 32'(div_load), 0);
    check("R7 timing_err", 32'(terr), 0);
    check_fields("R7 fields");
    rst_n = 1'b1;
    idle(5);

    // R1 R2 R3 R5: table of words
    for (int v = 0; v < NV; v++) begin
      r0 = ref_cnt; d0 = div_cnt;
      send_bits(32'(VEC[v]), 19);
      pulse_le();
      model_commit(VEC[v]);
      check(VEC[v][0] ? "R5 R2 ref strobe count" : "R5 R3 ref strobe count",
            32'(ref_cnt - r0), VEC[v][0] ? 1 : 0);
      check(VEC[v][0] ? "R5 R2 div strobe count" : "R5 R3 div strobe count",
            32'(div_cnt - d0), VEC[v][0] ? 0 : 1);
      check_fields(VEC[v][0] ? "R1 R2 fields" : "R1 R3 fields");
    end
    check("R6 no error on clean transfers", 32'(err_cnt), 0);

    // R4: shifting without a load edge changes nothing
    r0 = ref_cnt; d0 = div_cnt;
    send_bits(32'h3C3C3, 19);
    check_fields("R4 shift only");
    check("R4 no strobe on shift", 32'((ref_cnt - r0) + (div_cnt - d0)), 0);

    // R8: over-long stream keeps last 19 bits
    send_bits(32'h1F02468, 25);
    pulse_le();
    model_commit(19'(32'h1F02468));
    check_fields("R8 last 19 bits");

    // R6: load edge while shift clock high is refused
    send_bits(32'h12345, 19);
    r0 = ref_cnt; d0 = div_cnt; x0 = err_cnt;
    sdata = 1'b0;
    idle(4);
    sclk = 1'b1;
    idle(6);
    sle = 1'b1;
    idle(8);
    check("R6 error pulse on rise", 32'(err_cnt - x0), 1);
    check("R6 no strobe", 32'((ref_cnt - r0) + (div_cnt - d0)), 0);
    check_fields("R6 fields held");
    sle = 1'b0;
    idle(8);
    check("R6 error pulse on fall", 32'(err_cnt - x0), 2);
    sclk = 1'b0;
    idle(8);

    // R4: falling load enable with clock low does nothing
    sle = 1'b1;
    r0 = ref_cnt; d0 = div_cnt;
    idle(8);
    model_commit(19'((32'h12345 << 1) & 32'h7FFFF));
    check("R4 rise with clock low commits", 32'(div_cnt - d0), 1);
    r0 = ref_cnt; d0 = div_cnt; x0 = err_cnt;
    sle = 1'b0;
    idle(8);
    check("R4 no strobe on fall", 32'((ref_cnt - r0) + (div_cnt - d0)), 0);
    check("R4 no error on fall", 32'(err_cnt - x0), 0);
    check_fields("R4 fields after fall");

    finish_run();
  end

endmodule